// File: doc/BRIEF.md
# Serial Configuration Sweep Loader

This block keeps six 32-bit configuration words that a host writes over a simple write port. A single trigger write starts an automatic sweep that sends the words, one after another, to three serial devices. The devices are a data converter and two clock synthesizers: one synthesizer makes the sampling clock for the ADCs, the other makes the DAC clock. Each device has its own port with three lines: an active-low load strobe, a serial clock and a serial data line. By convention, the top nibble of every word holds its own register number, so word 5 carries 0x5 in bits 31:28. The block shifts that nibble out like any other bit.

Words 0 to 4 go to the converter port, each as its own 32-bit transfer. Word 5 holds the divider and clock-source settings for both synthesizers. It is split into two fields, each sent to its own synthesizer port. The serial clock is the system clock divided down by a parameter. Every transfer is followed by one serial period with that port's load strobe low. A busy flag covers the whole sweep, and a one-cycle done pulse marks its end. While busy, the block ignores register writes and repeated triggers, so the words on the wires cannot change in the middle of a sweep.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `busy` and `done` are 0, every serial clock and data line is 0 and every load strobe is 1.
- R2: A write with `wr_addr` 0 to 5 stores `wr_data` in that register when the block is idle. A write to address 0xF with `wr_data` bit 0 set starts a sweep.
- R3: A sweep first sends words 0, 1, 2, 3, 4 in that order on the converter port, each as 32 bits, most significant bit first.
- R4: After the converter transfers, word 5 bits 13:0 go to the ADC-clock synthesizer port, and then word 5 bits 27:14 go to the DAC-clock synthesizer port. Each field is 14 bits, MSB first.
- R5: A serial clock rests low and toggles only during a transfer, with a period of 2*HALF_DIV system clocks. Data changes only on the falling serial clock edge and stays stable while the clock is high.
- R6: After the last bit of each transfer, that port's load strobe is low for exactly one serial period with its clock low. At most one load strobe is low at a time.
- R7: `busy` goes high in the cycle after the trigger is accepted and stays high for (5*33 + 2*15) * 2*HALF_DIV cycles.
- R8: A trigger write while `busy` is high is ignored: the sweep neither restarts nor gets longer.
- R9: A register write while `busy` is high is ignored. The register keeps its old value for the current sweep and for later sweeps.
- R10: `done` pulses high for exactly one cycle, at the first cycle `busy` is low after a sweep.
- R11: Writes to addresses 6 to 0xE, and writes to 0xF with bit 0 clear, neither start a sweep nor change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address (0-5 registers, 0xF trigger) |
| wr_data | input | 32 | Host write data |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at sweep end |
| dac_sclk | output | 1 | Converter port serial clock |
| dac_sdata | output | 1 | Converter port serial data |
| dac_load_n | output | 1 | Converter port load strobe, active low |
| adcsyn_sclk | output | 1 | ADC-clock synthesizer serial clock |
| adcsyn_sdata | output | 1 | ADC-clock synthesizer serial data |
| adcsyn_load_n | output | 1 | ADC-clock synthesizer load strobe, active low |
| dacsyn_sclk | output | 1 | DAC-clock synthesizer serial clock |
| dacsyn_sdata | output | 1 | DAC-clock synthesizer serial data |
| dacsyn_load_n | output | 1 | DAC-clock synthesizer load strobe, active low |

## Verification
The assertions check the line rules on every cycle:
- data holds while its serial clock is high;
- the clock stays low during a load strobe;
- no two load strobes are low together;
- all lines rest when idle;
- the stored words stay frozen while busy;
- `done` appears only as `busy` falls.

Only the bench scenarios can show the rest: which word reaches which port, in what order and bit order, the exact serial period, strobe width and sweep length, and that a repeated trigger, a blocked write or an unused address leaves the next sweep's data unchanged.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial configuration sweep loader.
// Assumes three serial targets, indexed as listed in scl_port_e.
package scl_pkg;
    localparam int NUM_PORTS = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } scl_state_e;

    typedef enum logic [1:0] {
        PORT_DAC    = 2'd0,
        PORT_ADCSYN = 2'd1,
        PORT_DACSYN = 2'd2
    } scl_port_e;
endpackage

// File: rtl/scl_regfile.sv
`timescale 1ns/1ps
// Host-writable register bank with trigger decode.
// Stores NUM_REGS words at addresses 0..NUM_REGS-1. While busy_i is high,
// every write is refused. trig_o is a combinational one-cycle request,
// raised for a write to TRIG_ADDR with bit TRIG_BIT set while idle.
module scl_regfile #(
    parameter int                REG_W     = 32,
    parameter int                ADDR_W    = 4,
    parameter int                NUM_REGS  = 6,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = '1,
    parameter int                TRIG_BIT  = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [REG_W-1:0]               wr_data,
    input  logic                           busy_i,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_o,
    output logic                           trig_o
);
    logic wr_ok;

    // Purpose: a host access is accepted only while no sweep runs.
    assign wr_ok = wr_en && !busy_i;

    // Purpose: trigger request from the dedicated control address.
    assign trig_o = wr_ok && (wr_addr == TRIG_ADDR) && wr_data[TRIG_BIT];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [REG_W-1:0] word_q;

        // Purpose: capture the host word for register r.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_ok && (wr_addr == ADDR_W'(r))) begin
                word_q <= wr_data;
            end
        end

        assign regs_o[r] = word_q;
    end
endmodule

// File: rtl/scl_sequencer.sv
`timescale 1ns/1ps
// Sweep sequencer: walks seven transfer slots. Slots 0..NUM_REGS-2 send
// whole words to the converter port. The next slot sends the low
// synthesizer field of the last word, and the final slot sends the high
// field. Each bit lasts two half periods of HALF_DIV clocks (clock low,
// then high). Each slot ends with a full serial period of load strobe.
// Assumes 2*SYN_W <= REG_W.
module scl_sequencer
    import scl_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int SYN_W    = 14,
    parameter int HALF_DIV = 2,
    parameter int NUM_REGS = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trig_i,
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs_i,
    output scl_state_e                     state_o,
    output scl_port_e                      port_o,
    output logic                           phase_o,
    output logic                           bit_o,
    output logic                           busy_o,
    output logic                           done_o
);
    localparam int NUM_SLOTS = NUM_REGS + 1;
    localparam int DAC_SLOTS = NUM_REGS - 1;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int BIT_W     = $clog2(REG_W);
    localparam int HC_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    scl_state_e         state_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [BIT_W-1:0]   bit_q;
    logic [HC_W-1:0]    hcnt_q;
    logic               phase_q;
    logic               done_q;
    logic               half_end;
    logic [REG_W-1:0]   cur_word;

    // Purpose: index of the first (MSB) bit for a given slot.
    function automatic logic [BIT_W-1:0] first_bit(input logic [SLOT_W-1:0] s);
        return (s < SLOT_W'(DAC_SLOTS)) ? BIT_W'(REG_W - 1) : BIT_W'(SYN_W - 1);
    endfunction

    // Purpose: mark the last system clock of a half serial period.
    assign half_end = (hcnt_q == HC_W'(HALF_DIV - 1));

    // Purpose: pick the word or synthesizer field that the current slot sends.
    always_comb begin
        cur_word = '0;
        if (slot_q < SLOT_W'(DAC_SLOTS)) begin
            cur_word = regs_i[slot_q];
        end else if (slot_q == SLOT_W'(DAC_SLOTS)) begin
            cur_word[SYN_W-1:0] = regs_i[NUM_REGS-1][SYN_W-1:0];
        end else begin
            cur_word[SYN_W-1:0] = regs_i[NUM_REGS-1][2*SYN_W-1:SYN_W];
        end
    end

    // Purpose: map the slot number to its serial target.
    always_comb begin
        if (slot_q < SLOT_W'(DAC_SLOTS)) begin
            port_o = PORT_DAC;
        end else if (slot_q == SLOT_W'(DAC_SLOTS)) begin
            port_o = PORT_ADCSYN;
        end else begin
            port_o = PORT_DACSYN;
        end
    end

    // Purpose: advance the idle / shift / load walk across all slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            bit_q   <= '0;
            hcnt_q  <= '0;
            phase_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_i) begin
                        state_q <= ST_SHIFT;
                        slot_q  <= '0;
                        bit_q   <= first_bit('0);
                        hcnt_q  <= '0;
                        phase_q <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (half_end) begin
                        hcnt_q  <= '0;
                        phase_q <= ~phase_q;
                        if (phase_q) begin
                            if (bit_q == '0) begin
                                state_q <= ST_LOAD;
                            end else begin
                                bit_q <= bit_q - 1'b1;
                            end
                        end
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (half_end) begin
                        hcnt_q  <= '0;
                        phase_q <= ~phase_q;
                        if (phase_q) begin
                            if (slot_q == LAST_SLOT) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                slot_q  <= slot_q + 1'b1;
                                bit_q   <= first_bit(slot_q + 1'b1);
                                state_q <= ST_SHIFT;
                            end
                        end
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign phase_o = phase_q;
    assign bit_o   = cur_word[bit_q];
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
endmodule

// File: rtl/scl_port_drive.sv
`timescale 1ns/1ps
// Per-target line driver: steers the sequencer's clock phase, data bit and
// load window to the selected port and holds every other port at rest
// (clock low, data low, load high). Outputs depend only on registered
// sequencer state.
module scl_port_drive
    import scl_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  scl_state_e           state_i,
    input  scl_port_e            port_i,
    input  logic                 phase_i,
    input  logic                 bit_i,
    output logic [NUM_PORTS-1:0] sclk_o,
    output logic [NUM_PORTS-1:0] sdata_o,
    output logic [NUM_PORTS-1:0] load_n_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;

        // Purpose: this port is the current transfer target.
        assign sel = (port_i == scl_port_e'(p));

        // Purpose: drive the clock, data and strobe of port p.
        always_comb begin
            sclk_o[p]   = sel && (state_i == ST_SHIFT) && phase_i;
            sdata_o[p]  = sel && (state_i == ST_SHIFT) && bit_i;
            load_n_o[p] = !(sel && (state_i == ST_LOAD));
        end
    end
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
// Top level: register bank, sweep sequencer and per-port line drivers.
// Assumes HALF_DIV >= 1 and 2*SYN_W <= REG_W - 4, so that the synthesizer
// fields stay below the register-number nibble.
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int ADDR_W   = 4,
    parameter int SYN_W    = 14,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              busy,
    output logic              done,
    output logic              dac_sclk,
    output logic              dac_sdata,
    output logic              dac_load_n,
    output logic              adcsyn_sclk,
    output logic              adcsyn_sdata,
    output logic              adcsyn_load_n,
    output logic              dacsyn_sclk,
    output logic              dacsyn_sdata,
    output logic              dacsyn_load_n
);
    localparam int NUM_REGS = 6;

    logic [NUM_REGS-1:0][REG_W-1:0] regs_w;
    logic                           trig_w;
    scl_state_e                     state_w;
    scl_port_e                      port_w;
    logic                           phase_w;
    logic                           bit_w;
    logic [NUM_PORTS-1:0]           sclk_w;
    logic [NUM_PORTS-1:0]           sdata_w;
    logic [NUM_PORTS-1:0]           load_n_w;

    scl_regfile #(
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .TRIG_ADDR('1),
        .TRIG_BIT (0)
    ) regfile_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .busy_i (busy),
        .regs_o (regs_w),
        .trig_o (trig_w)
    );

    scl_sequencer #(
        .REG_W   (REG_W),
        .SYN_W   (SYN_W),
        .HALF_DIV(HALF_DIV),
        .NUM_REGS(NUM_REGS)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_w),
        .regs_i (regs_w),
        .state_o(state_w),
        .port_o (port_w),
        .phase_o(phase_w),
        .bit_o  (bit_w),
        .busy_o (busy),
        .done_o (done)
    );

    scl_port_drive #(
        .NUM_PORTS(NUM_PORTS)
    ) drive_i (
        .state_i (state_w),
        .port_i  (port_w),
        .phase_i (phase_w),
        .bit_i   (bit_w),
        .sclk_o  (sclk_w),
        .sdata_o (sdata_w),
        .load_n_o(load_n_w)
    );

    // Purpose: fan the port vectors out to named pins.
    assign dac_sclk      = sclk_w[PORT_DAC];
    assign dac_sdata     = sdata_w[PORT_DAC];
    assign dac_load_n    = load_n_w[PORT_DAC];
    assign adcsyn_sclk   = sclk_w[PORT_ADCSYN];
    assign adcsyn_sdata  = sdata_w[PORT_ADCSYN];
    assign adcsyn_load_n = load_n_w[PORT_ADCSYN];
    assign dacsyn_sclk   = sclk_w[PORT_DACSYN];
    assign dacsyn_sdata  = sdata_w[PORT_DACSYN];
    assign dacsyn_load_n = load_n_w[PORT_DACSYN];
endmodule

// File: rtl/scl_checker.sv
`timescale 1ns/1ps
// Protocol checker for serial_cfg_loader, attached with bind below.
// Watches the per-port line vectors, the busy/done status and the
// stored register words.
module scl_checker #(
    parameter int REG_W     = 32,
    parameter int NUM_REGS  = 6,
    parameter int NUM_PORTS = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           busy,
    input logic                           done,
    input logic [NUM_PORTS-1:0]           sclk_v,
    input logic [NUM_PORTS-1:0]           sdata_v,
    input logic [NUM_PORTS-1:0]           load_n_v,
    input logic [NUM_REGS-1:0][REG_W-1:0] regs
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R5
        data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sclk_v[p] |-> $stable(sdata_v[p]));
        // R6
        load_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load_n_v[p] |-> !sclk_v[p]);
    end

    // R6
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~load_n_v) <= 1);

    // R5
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((sclk_v == '0) && (load_n_v == '1)));

    // R9
    frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(regs));

    // R10
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind serial_cfg_loader scl_checker #(
    .REG_W    (REG_W),
    .NUM_REGS (NUM_REGS),
    .NUM_PORTS(NUM_PORTS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .sclk_v  (sclk_w),
    .sdata_v (sdata_w),
    .load_n_v(load_n_w),
    .regs    (regs_w)
);

// File: tb/serial_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb_top;
    localparam int HALF_DIV = 2;
    localparam int SYN_W    = 14;
    localparam int SPER     = 2 * HALF_DIV;
    localparam int SWEEP_CYC = (5 * 33 + 2 * (SYN_W + 1)) * SPER;
    localparam int NVEC = 3;

    localparam logic [31:0] VEC [0:NVEC-1][0:5] = '{
        '{32'h00A1B2C3, 32'h12345678, 32'h2F0F0F0F, 32'h3000FFFF, 32'h4AAA5555, 32'h51234567},
        '{32'h0FFFFFFF, 32'h10000001, 32'h28000000, 32'h3C3C3C3C, 32'h4FFF0000, 32'h5FFFFFFF},
        '{32'h00000000, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444, 32'h50000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        busy, done;
    logic        dac_sclk, dac_sdata, dac_load_n;
    logic        adcsyn_sclk, adcsyn_sdata, adcsyn_load_n;
    logic        dacsyn_sclk, dacsyn_sdata, dacsyn_load_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_cfg_loader #(.REG_W(32), .ADDR_W(4), .SYN_W(SYN_W), .HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done),
        .dac_sclk(dac_sclk), .dac_sdata(dac_sdata), .dac_load_n(dac_load_n),
        .adcsyn_sclk(adcsyn_sclk), .adcsyn_sdata(adcsyn_sdata), .adcsyn_load_n(adcsyn_load_n),
        .dacsyn_sclk(dacsyn_sclk), .dacsyn_sdata(dacsyn_sdata), .dacsyn_load_n(dacsyn_load_n)
    );

    wire [2:0] sclk_b  = {dacsyn_sclk, adcsyn_sclk, dac_sclk};
    wire [2:0] sdata_b = {dacsyn_sdata, adcsyn_sdata, dac_sdata};
    wire [2:0] load_b  = {dacsyn_load_n, adcsyn_load_n, dac_load_n};

    // Monitor: decodes the serial lines at negedge, away from the active edge.
    logic        mon_clr = 1'b0;
    logic [31:0] sh [3];
    int          nb [3];
    logic [31:0] words [3][8];
    int          wbits [3][8];
    int          wstart [3][8];
    int          wcnt [3];
    int          last_rise [3];
    int          low_start [3];
    logic [2:0]  prev_sclk = '0, prev_sd = '0, prev_ld = '1;
    int per_err = 0, hold_err = 0, low_err = 0;
    int busy_cnt = 0, done_cnt = 0, rise_total = 0, cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            for (int p = 0; p < 3; p++) begin
                sh[p] = '0; nb[p] = 0; wcnt[p] = 0; last_rise[p] = 0; low_start[p] = 0;
            end
            per_err = 0; hold_err = 0; low_err = 0;
            busy_cnt = 0; done_cnt = 0; rise_total = 0;
        end else begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            for (int p = 0; p < 3; p++) begin
                if (sclk_b[p] && !prev_sclk[p]) begin
                    if (nb[p] > 0 && (cyc - last_rise[p]) != SPER) per_err++;
                    last_rise[p] = cyc;
                    sh[p] = {sh[p][30:0], sdata_b[p]};
                    nb[p]++;
                    rise_total++;
                end
                if (sclk_b[p] && prev_sclk[p] && (sdata_b[p] != prev_sd[p])) hold_err++;
                if (!load_b[p] && prev_ld[p]) begin
                    low_start[p] = cyc;
                    if (wcnt[p] < 8) begin
                        words[p][wcnt[p]]  = sh[p];
                        wbits[p][wcnt[p]]  = nb[p];
                        wstart[p][wcnt[p]] = cyc;
                    end
                    wcnt[p]++;
                    sh[p] = '0;
                    nb[p] = 0;
                end
                if (load_b[p] && !prev_ld[p] && (cyc - low_start[p]) != SPER) low_err++;
            end
        end
        prev_sclk = sclk_b;
        prev_sd   = sdata_b;
        prev_ld   = load_b;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < SWEEP_CYC * 2) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Compare a finished sweep against the expected six words.
    task automatic check_sweep(input logic [31:0] e0, e1, e2, e3, e4, e5);
        logic [31:0] ew [5];
        ew = '{e0, e1, e2, e3, e4};
        check(wcnt[0] == 5, "R3 converter transfer count", wcnt[0], 5);
        for (int i = 0; i < 5; i++) begin
            check(words[0][i] == ew[i], "R2/R3 converter word", words[0][i], ew[i]);
            check(wbits[0][i] == 32, "R3 converter bit count", wbits[0][i], 32);
        end
        check(wcnt[1] == 1 && words[1][0] == {18'd0, e5[13:0]}, "R4 adc synth field", words[1][0], e5[13:0]);
        check(wbits[1][0] == SYN_W, "R4 adc synth bit count", wbits[1][0], SYN_W);
        check(wcnt[2] == 1 && words[2][0] == {18'd0, e5[27:14]}, "R4 dac synth field", words[2][0], e5[27:14]);
        check(wbits[2][0] == SYN_W, "R4 dac synth bit count", wbits[2][0], SYN_W);
        check(wstart[0][4] < wstart[1][0] && wstart[1][0] < wstart[2][0], "R4 port order",
              wstart[1][0], wstart[2][0]);
        check(per_err == 0 && hold_err == 0, "R5 clock period / data hold", per_err + hold_err, 0);
        check(low_err == 0, "R6 load strobe width", low_err, 0);
        check(busy_cnt == SWEEP_CYC, "R7 busy length", busy_cnt, SWEEP_CYC);
        check(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 status after reset", {busy, done}, 0);
        check(sclk_b == 3'b000 && sdata_b == 3'b000, "R1 clock/data after reset", {sclk_b, sdata_b}, 0);
        check(load_b == 3'b111, "R1 load strobes after reset", load_b, 3'b111);

        // Vector walk: load the six words, trigger, check the whole sweep.
        for (int v = 0; v < NVEC; v++) begin
            for (int r = 0; r < 6; r++) host_write(4'(r), VEC[v][r]);
            clear_mon();
            host_write(4'hF, 32'h1);
            wait_idle();
            check_sweep(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
        end

        // R11: unused address and trigger word without its start bit.
        clear_mon();
        host_write(4'h6, 32'hDEADBEEF);
        host_write(4'hA, 32'hFFFFFFFF);
        host_write(4'hF, 32'hFFFFFFFE);
        repeat (40) @(negedge clk);
        check(busy_cnt == 0 && rise_total == 0, "R11 no sweep from ignored writes", busy_cnt + rise_total, 0);
        clear_mon();
        host_write(4'hF, 32'h1);
        wait_idle();
        check_sweep(VEC[NVEC-1][0], VEC[NVEC-1][1], VEC[NVEC-1][2], VEC[NVEC-1][3],
                    VEC[NVEC-1][4], VEC[NVEC-1][5]); // R11 words unchanged

        // R8 and R9: retrigger and register writes during a sweep.
        clear_mon();
        host_write(4'hF, 32'h1);
        repeat (100) @(negedge clk);
        host_write(4'hF, 32'h1);        // R8 ignored
        host_write(4'h0, 32'h0BADCAFE); // R9 ignored
        host_write(4'h5, 32'h5FFFFFFF); // R9 ignored
        wait_idle();
        check(busy_cnt == SWEEP_CYC, "R8 sweep not extended by retrigger", busy_cnt, SWEEP_CYC);
        check(wcnt[0] == 5 && done_cnt == 1, "R8 sweep not restarted", wcnt[0], 5);
        clear_mon();
        host_write(4'hF, 32'h1);
        wait_idle();
        check(words[0][0] == VEC[NVEC-1][0], "R9 word 0 kept old value", words[0][0], VEC[NVEC-1][0]);
        check(words[2][0] == {18'd0, VEC[NVEC-1][5][27:14]}, "R9 word 5 kept old value",
              words[2][0], VEC[NVEC-1][5][27:14]);

        // R1: reset in the middle of a sweep returns lines to rest.
        host_write(4'hF, 32'h1);
        repeat (50) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0 && sclk_b == 3'b000 && load_b == 3'b111, "R1 mid-sweep reset",
              {busy, sclk_b, load_b}, 4'b0111);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after reset release", {busy, done}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule